// File: doc/BRIEF.md
# Fused Single-Precision Two-Term Dot Product

This block takes four single-precision floating-point operands and returns either the sum of the two products A·B + C·D or their difference A·B − C·D. A select input picks the mode. Both significand products are kept exact at their full 48-bit width. Neither product is normalized or rounded before the two are combined. The block applies a single normalization and a single round-to-nearest-even step to the combined value. As a result, the output can differ in its last bit from a chain of separate multipliers and an adder, and the fused answer is the more accurate one. The difference mode is meant for the real and imaginary parts of a complex multiply.

The block is a free-running pipeline of four register stages:

1. Significand multiply.
2. Alignment of the product with the smaller exponent against the larger one.
3. Signed add or subtract.
4. Normalize, round and pack.

A new operand set may be presented every cycle. Each result comes out with a fixed latency, marked by an output valid. Subnormal operands are treated as zero, and results below the normal range are flushed to +0. Results that are too large become a signed infinity and raise an overflow flag. If any operand has an all-ones exponent, the result is a single canonical quiet NaN.

Top module: `fdp_dot2`

## Requirements
- R1: With `sub_sel` low, `result` is A·B + C·D rounded once to single precision.
- R2: With `sub_sel` high, `result` is A·B − C·D rounded once; the sign of C·D is inverted before the combination.
- R3: Products are combined unrounded: (1+2^-12)·(1+2^-12) − 1·1 yields exactly 2^-11 + 2^-24 (0x3A000400), not 2^-11.
- R4: Rounding is to nearest with ties to even: exact ties keep an even last bit, and any nonzero bit below the guard position forces rounding up when the guard bit is set.
- R5: An operand whose exponent field is 0 (zero or subnormal) makes its product contribute exactly zero.
- R6: A result whose magnitude is exactly zero, or whose biased exponent after rounding is 0 or below, is output as +0 (0x00000000).
- R7: A result whose biased exponent after rounding is 255 or more is output as infinity with the sign of the combined value (0x7F800000 or 0xFF800000), and `overflow` is high with that result.
- R8: If any operand has an exponent field of all ones, `result` is 0x7FC00000 and `overflow` is low.
- R9: `out_valid` is high exactly in the fourth cycle after the cycle in which `in_valid` was high, and `result`/`overflow` belong to that operand set.
- R10: Operand sets presented on consecutive cycles each produce their own result on consecutive cycles, in order.
- R11: While reset is asserted, `out_valid`, `result` and `overflow` are 0. Operand sets presented while reset is asserted produce no output.
- R12: When rounding carries out of the significand, the exponent increments and the fraction becomes zero (for example, (2−2^-23) + 2^-24 gives 2.0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set valid this cycle |
| sub_sel | input | 1 | 1 selects A·B − C·D, 0 selects A·B + C·D |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| op_c | input | 32 | Operand C, single precision |
| op_d | input | 32 | Operand D, single precision |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Single-precision result |
| overflow | output | 1 | Result overflowed to infinity (qualified by out_valid) |

## Verification
Every result is due in the fourth cycle after the cycle in which its operands were driven. Operand sets issued back to back therefore leave the pipeline on consecutive cycles in issue order. The driver stamps each expected item with the cycle of issue. The monitor pops the oldest item whenever `out_valid` is seen at a falling edge, then compares both the value and the elapsed cycle count against four. A valid with no pending item counts as a failure, and so does a pending item that is overdue with no valid.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXT_W    = 3;
    localparam int ALN_W    = PROD_W + EXT_W;
    localparam int SUM_W    = ALN_W + 1;
    localparam int PE_W     = EXP_W + 3;
    localparam int RE_W     = PE_W + 1;
    localparam int SH_W     = $clog2(ALN_W + 1);
    localparam int LZ_W     = $clog2(SUM_W);
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_ALL  = (1 << EXP_W) - 1;
    localparam int ONE_POS  = EXT_W + 2 * FRAC_W;
    localparam int NPROD    = 2;
    localparam int PIPE_LAT = 4;
    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic                   sgn;
        logic                   zero;
        logic signed [PE_W-1:0] exp;
        logic [PROD_W-1:0]      sig;
    } prod_t;

    typedef struct packed {
        logic                   sgn_big;
        logic                   sgn_sml;
        logic signed [PE_W-1:0] exp;
        logic [ALN_W-1:0]       big;
        logic [ALN_W-1:0]       sml;
    } aln_t;

    typedef struct packed {
        logic                   sgn;
        logic signed [PE_W-1:0] exp;
        logic [SUM_W-1:0]       mag;
    } sum_t;

    // Exact product of two operands; exponent field 0 flushes to zero (R5)
    function automatic prod_t form_product(input logic [WORD_W-1:0] x,
                                           input logic [WORD_W-1:0] y,
                                           input logic              neg);
        prod_t p;
        logic [EXP_W-1:0] ex, ey;
        ex     = x[WORD_W-2 -: EXP_W];
        ey     = y[WORD_W-2 -: EXP_W];
        p.sgn  = x[WORD_W-1] ^ y[WORD_W-1] ^ neg;
        p.zero = (ex == '0) || (ey == '0);
        p.exp  = PE_W'(ex) + PE_W'(ey) - PE_W'(BIAS);
        p.sig  = PROD_W'({1'b1, x[FRAC_W-1:0]}) * PROD_W'({1'b1, y[FRAC_W-1:0]});
        return p;
    endfunction

    function automatic logic is_special(input logic [WORD_W-1:0] x);
        return x[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}};
    endfunction

endpackage

// File: rtl/fdp_mul_stage.sv
module fdp_mul_stage
    import fdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    input  logic [WORD_W-1:0] op_d,
    input  logic              sub_sel,
    output prod_t             prod_q [NPROD],
    output logic              special_q
);

    prod_t prod_n [NPROD];
    logic  special_n;

    always_comb begin
        prod_n[0] = form_product(op_a, op_b, 1'b0);
        // difference mode inverts the sign of the second product (R2)
        prod_n[1] = form_product(op_c, op_d, sub_sel);
        special_n = is_special(op_a) | is_special(op_b) |
                    is_special(op_c) | is_special(op_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPROD; i++) prod_q[i] <= '0;
            special_q <= 1'b0;
        end else begin
            for (int i = 0; i < NPROD; i++) prod_q[i] <= prod_n[i];
            special_q <= special_n;
        end
    end

endmodule

// File: rtl/fdp_align_stage.sv
module fdp_align_stage
    import fdp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  prod_t prod_i [NPROD],
    input  logic  special_i,
    output aln_t  aln_q,
    output logic  special_q
);

    localparam logic signed [PE_W-1:0] ALN_LIM = PE_W'(ALN_W);

    prod_t                  hi, lo;
    logic                   swap, lost;
    logic signed [PE_W-1:0] dif;
    logic [SH_W-1:0]        shamt;
    logic [ALN_W-1:0]       hi_v, lo_v, lo_s;
    aln_t                   aln_n;

    always_comb begin
        // larger product exponent wins; a zero product never does
        if (prod_i[1].zero)      swap = 1'b0;
        else if (prod_i[0].zero) swap = 1'b1;
        else                     swap = prod_i[1].exp > prod_i[0].exp;
        hi    = swap ? prod_i[1] : prod_i[0];
        lo    = swap ? prod_i[0] : prod_i[1];
        hi_v  = hi.zero ? '0 : {hi.sig, {EXT_W{1'b0}}};
        lo_v  = lo.zero ? '0 : {lo.sig, {EXT_W{1'b0}}};
        dif   = hi.exp - lo.exp;
        shamt = (dif > ALN_LIM) ? SH_W'(ALN_W) : dif[SH_W-1:0];
        lost  = 1'b0;
        for (int i = 0; i < ALN_W; i++) begin
            if (SH_W'(i) < shamt) lost = lost | lo_v[i];
        end
        lo_s = (lo_v >> shamt) | ALN_W'(lost);
        aln_n.sgn_big = hi.sgn;
        aln_n.sgn_sml = lo.sgn;
        aln_n.exp     = hi.exp;
        aln_n.big     = hi_v;
        aln_n.sml     = lo_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aln_q     <= '0;
            special_q <= 1'b0;
        end else begin
            aln_q     <= aln_n;
            special_q <= special_i;
        end
    end

endmodule

// File: rtl/fdp_addsub_stage.sv
module fdp_addsub_stage
    import fdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  aln_t aln_i,
    input  logic special_i,
    output sum_t sum_q,
    output logic special_q
);

    sum_t sum_n;

    always_comb begin
        sum_n.exp = aln_i.exp;
        if (aln_i.sgn_big == aln_i.sgn_sml) begin
            sum_n.mag = {1'b0, aln_i.big} + {1'b0, aln_i.sml};
            sum_n.sgn = aln_i.sgn_big;
        end else if (aln_i.big >= aln_i.sml) begin
            sum_n.mag = {1'b0, aln_i.big - aln_i.sml};
            sum_n.sgn = aln_i.sgn_big;
        end else begin
            // equal exponents may leave the smaller magnitude on top
            sum_n.mag = {1'b0, aln_i.sml - aln_i.big};
            sum_n.sgn = aln_i.sgn_sml;
        end
        if (sum_n.mag == '0) sum_n.sgn = 1'b0;  // exact zero is +0 (R6)
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q     <= '0;
            special_q <= 1'b0;
        end else begin
            sum_q     <= sum_n;
            special_q <= special_i;
        end
    end

endmodule

// File: rtl/fdp_norm_round.sv
module fdp_norm_round
    import fdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sum_t              sum_i,
    input  logic              special_i,
    output logic [WORD_W-1:0] result_q,
    output logic              ovf_q
);

    localparam int FR_W = FRAC_W + 1;

    logic [LZ_W-1:0]        lead;
    logic [SUM_W-1:0]       norm;
    logic [FRAC_W-1:0]      frac_t;
    logic                   grd, stk, rup;
    logic [FR_W-1:0]        frac_r;
    logic signed [RE_W-1:0] e;
    logic [WORD_W-1:0]      res_n;
    logic                   ovf_n;

    always_comb begin
        lead = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (sum_i.mag[i]) lead = LZ_W'(i);
        end
        norm   = sum_i.mag << (LZ_W'(SUM_W - 1) - lead);
        frac_t = norm[SUM_W-2 -: FRAC_W];
        grd    = norm[SUM_W-2-FRAC_W];
        stk    = |norm[SUM_W-3-FRAC_W:0];
        rup    = grd & (stk | frac_t[0]);           // R4
        frac_r = {1'b0, frac_t} + FR_W'(rup);
        // carry out of the fraction bumps the exponent (R12)
        e      = RE_W'(sum_i.exp) + RE_W'(lead) - RE_W'(ONE_POS) + RE_W'(frac_r[FRAC_W]);
        ovf_n  = 1'b0;
        if (special_i) begin
            res_n = QNAN_WORD;                                       // R8
        end else if (!norm[SUM_W-1]) begin
            res_n = '0;                                              // R6
        end else if (e >= EXP_ALL) begin
            res_n = {sum_i.sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};      // R7
            ovf_n = 1'b1;
        end else if (e <= 0) begin
            res_n = '0;                                              // R6
        end else begin
            res_n = {sum_i.sgn, e[EXP_W-1:0], frac_r[FRAC_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            result_q <= res_n;
            ovf_q    <= ovf_n;
        end
    end

endmodule

// File: rtl/fdp_dot2.sv
module fdp_dot2
    import fdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sub_sel,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    input  logic [WORD_W-1:0] op_d,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              overflow
);

    prod_t                prod_q [NPROD];
    aln_t                 aln_q;
    sum_t                 sum_q;
    logic                 spec1_q, spec2_q, spec3_q;
    logic                 ovf_q;
    logic [PIPE_LAT-1:0]  vld_q;

    // valid travels beside the data, one bit per stage (R9, R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
    end

    fdp_mul_stage u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_c      (op_c),
        .op_d      (op_d),
        .sub_sel   (sub_sel),
        .prod_q    (prod_q),
        .special_q (spec1_q)
    );

    fdp_align_stage u_aln (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_i    (prod_q),
        .special_i (spec1_q),
        .aln_q     (aln_q),
        .special_q (spec2_q)
    );

    fdp_addsub_stage u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .aln_i     (aln_q),
        .special_i (spec2_q),
        .sum_q     (sum_q),
        .special_q (spec3_q)
    );

    fdp_norm_round u_rnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .sum_i     (sum_q),
        .special_i (spec3_q),
        .result_q  (result),
        .ovf_q     (ovf_q)
    );

    assign out_valid = vld_q[PIPE_LAT-1];
    assign overflow  = ovf_q & out_valid;

endmodule

// File: rtl/fdp_dot2_chk.sv
module fdp_dot2_chk
    import fdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              overflow
);

    localparam int CNT_W = $clog2(PIPE_LAT + 1);

    logic [CNT_W-1:0] warm_cnt;
    logic             warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             warm_cnt <= '0;
        else if (warm_cnt != CNT_W'(PIPE_LAT))  warm_cnt <= warm_cnt + 1'b1;
    end
    assign warm = (warm_cnt == CNT_W'(PIPE_LAT));

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, PIPE_LAT)));                       // R9

    AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (out_valid && result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R7

    AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2:0] == '0) |-> !result[WORD_W-1]);          // R6

    AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2 -: EXP_W] == '0) |-> (result[FRAC_W-1:0] == '0)); // R5

    AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}} && result[FRAC_W-1:0] != '0)
        |-> (result == QNAN_WORD && !overflow));                                  // R8

endmodule

bind fdp_dot2 fdp_dot2_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .result    (result),
    .overflow  (overflow)
);

// File: tb/tb_fdp_dot2.sv
module tb_fdp_dot2;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sub_sel = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        overflow;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [32:0] exp_q [$];
    int          cyc_q [$];
    string       tag_q [$];

    logic [32:0] m_exp;
    int          m_cyc;
    string       m_tag;

    fdp_dot2 dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sub_sel   (sub_sel),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_c      (op_c),
        .op_d      (op_d),
        .out_valid (out_valid),
        .result    (result),
        .overflow  (overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // driver: present one operand set and queue what must come out
    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d,
                         input logic sub, input logic [31:0] want,
                         input logic ovf, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; op_d = d;
        sub_sel = sub; in_valid = 1'b1;
        exp_q.push_back({ovf, want});
        cyc_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pop and compare when the design presents a result
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_errors++;
                    $display("FAIL R9: out_valid with nothing pending, got %h expected no output", result);
                end else begin
                    m_exp = exp_q.pop_front();
                    m_cyc = cyc_q.pop_front();
                    m_tag = tag_q.pop_front();
                    n_checks++;
                    if ({overflow, result} !== m_exp) begin
                        n_errors++;
                        $display("FAIL %s: got ovf=%b res=%h expected ovf=%b res=%h",
                                 m_tag, overflow, result, m_exp[32], m_exp[31:0]);
                    end
                    n_checks++;
                    if (cyc - m_cyc != LATENCY) begin
                        n_errors++;
                        $display("FAIL R9 (%s): latency got %0d expected %0d", m_tag, cyc - m_cyc, LATENCY);
                    end
                end
            end else if (exp_q.size() != 0 && (cyc - cyc_q[0]) > LATENCY) begin
                m_exp = exp_q.pop_front();
                m_cyc = cyc_q.pop_front();
                m_tag = tag_q.pop_front();
                n_checks++; n_errors++;
                $display("FAIL R9 (%s): no output after %0d cycles, expected res=%h",
                         m_tag, cyc - m_cyc, m_exp[31:0]);
            end
        end
    end

    initial begin
        // R11: operand set held valid during reset must not come out
        in_valid = 1'b1;
        op_a = 32'h3F800000; op_b = 32'h40000000; op_c = 32'h40400000; op_d = 32'h40800000;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || result !== 32'h0 || overflow !== 1'b0) begin
            n_errors++;
            $display("FAIL R11: reset state got v=%b res=%h ovf=%b expected v=0 res=00000000 ovf=0",
                     out_valid, result, overflow);
        end
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        op_a = '0; op_b = '0; op_c = '0; op_d = '0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0) begin
                n_errors++;
                $display("FAIL R11: out_valid after reset got %b expected 0", out_valid);
            end
        end

        // back-to-back stream (R10)
        issue(32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000, 1'b0, 32'h41600000, 1'b0, "R1 1*2+3*4");
        issue(32'hC0000000, 32'h40400000, 32'h3F000000, 32'h40800000, 1'b0, 32'hC0800000, 1'b0, "R1 -2*3+0.5*4");
        issue(32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000, 1'b1, 32'hC1200000, 1'b0, "R2 1*2-3*4");
        issue(32'h3F800000, 32'h3F800000, 32'h40800000, 32'h40800000, 1'b1, 32'hC1700000, 1'b0, "R2 1*1-4*4");
        issue(32'h3F800800, 32'h3F800800, 32'h3F800000, 32'h3F800000, 1'b1, 32'h3A000400, 1'b0, "R3 unrounded product");
        issue(32'h3F800000, 32'h3F800000, 32'h33800000, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, "R4 tie to even down");
        issue(32'h3F800000, 32'h3F800000, 32'h34400000, 32'h3F800000, 1'b0, 32'h3F800002, 1'b0, "R4 tie to even up");
        issue(32'h3F800000, 32'h3F800000, 32'h33820000, 32'h3F800000, 1'b0, 32'h3F800001, 1'b0, "R4 sticky up");
        issue(32'h3FFFFFFF, 32'h3F800000, 32'h33800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, "R12 round carry");
        idle(2);
        issue(32'h00000000, 32'h40A00000, 32'h40000000, 32'h40400000, 1'b0, 32'h40C00000, 1'b0, "R5 zero operand");
        idle(1);
        issue(32'h00000001, 32'h40800000, 32'h3F800000, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, "R5 subnormal operand");
        issue(32'h40400000, 32'h40800000, 32'h40400000, 32'h40800000, 1'b1, 32'h00000000, 1'b0, "R6 exact cancel");
        issue(32'h0D800000, 32'h0D800000, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0, "R6 underflow");
        issue(32'h8D800000, 32'h0D800000, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0, "R6 negative underflow");
        idle(3);
        issue(32'h7F000000, 32'h40800000, 32'h00000000, 32'h00000000, 1'b0, 32'h7F800000, 1'b1, "R7 overflow positive");
        issue(32'hFF000000, 32'h40800000, 32'h00000000, 32'h00000000, 1'b0, 32'hFF800000, 1'b1, "R7 overflow negative");
        issue(32'h7F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, "R8 special operand");
        issue(32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7FC00001, 1'b1, 32'h7FC00000, 1'b0, "R8 special in C*D");
        idle(LATENCY + 4);

        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R10: %0d results never produced, expected 0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule